// File: doc/BRIEF.md
# Shared Reservation Station Dispatch Pool

This block is a small pool of reservation stations. The integer unit, the two floating-point adders, the two floating-point multipliers and the floating-point divider all draw their work from it. Each cycle the reorder buffer may offer up to two instructions on two lanes. Each offered instruction carries a unit class, an operation code, two operand values, and for each operand a pending flag with the tag of its producer. It also carries its destination reorder-buffer index. The pool takes the offers into free stations and watches the result bus for the operands that are still missing. When a station has both operands and a unit of its class can take work, the pool sends the instruction to that unit and frees the station in the same cycle.

When several ready stations want the same unit class, the oldest goes first. Age is the distance of the destination index from the current reorder-buffer head, counted modulo the buffer depth. The divider cannot accept back-to-back work. After a divide starts, the pool holds every other divide until the divider latency has passed. A flush empties the pool at once.

Top module: `rs_pool`

## Requirements
- R1: After reset no station is occupied, no unit is issued to (`iss_valid` is all zero), and two valid offers with no flush are both accepted.
- R2: Lane 0 is accepted when it is valid, there is no flush and at least one station is free. Lane 1 is accepted when it is valid, there is no flush and enough stations are free: two if lane 0 is also valid, one if lane 0 is not valid. Lane 0 takes the lowest-numbered free station. Lane 1 takes the next free station, or the lowest one when lane 0 is not valid. A full pool accepts nothing.
- R3: An accepted instruction can issue no earlier than the cycle after it is accepted, and only once both of its operands are present. It is issued with its operation, both operand values and its destination index unchanged.
- R4: When the result bus is valid and its tag equals a pending producer tag, the bus data becomes that operand and the operand is no longer pending. This holds for stations already held and for offers being accepted in the same cycle.
- R5: Class codes are 0 integer, 1 float add, 2 float multiply and 3 float divide. Unit index 0 is the integer unit, 1 and 2 are the adders, 3 and 4 are the multipliers and 5 is the divider. An instruction is issued only to a unit of its own class.
- R6: Among the ready stations of one class, the one with the smallest age, (dst - rob_head) mod 6, is granted first.
- R7: Within a class, the units that can accept take work in increasing unit index. The k-th of them receives the k-th oldest ready station of that class.
- R8: A unit whose `fu_stall` bit is set receives nothing that cycle. Its instruction stays in its station, with its values kept, until a unit can take it.
- R9: Two divides start at least 8 cycles apart. A divide issued in cycle t allows the next divide in cycle t+8 at the earliest. A flush does not shorten this wait.
- R10: In a flush cycle nothing is accepted and nothing is issued. In the next cycle every station is free.
- R11: An issued station is released when it issues. From the next cycle it counts as free, and it holds no instruction for issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty all stations |
| rob_head | input | 3 | Current oldest reorder-buffer index |
| in_valid | input | 2 | Offer valid per lane |
| in_cls | input | 2x2 | Unit class per lane |
| in_op | input | 2x4 | Operation code per lane |
| in_vj | input | 2x32 | First operand value per lane |
| in_vk | input | 2x32 | Second operand value per lane |
| in_pj | input | 2 | First operand pending per lane |
| in_tj | input | 2x3 | First operand producer tag per lane |
| in_pk | input | 2 | Second operand pending per lane |
| in_tk | input | 2x3 | Second operand producer tag per lane |
| in_dst | input | 2x3 | Destination reorder-buffer index per lane |
| cdb_valid | input | 1 | Result bus valid |
| cdb_tag | input | 3 | Result bus producer tag |
| cdb_data | input | 32 | Result bus value |
| fu_stall | input | 6 | Per-unit cannot-accept flag |
| in_accept | output | 2 | Offer taken per lane |
| iss_valid | output | 6 | Issue strobe per unit |
| iss_op | output | 6x4 | Issued operation per unit |
| iss_vj | output | 6x32 | Issued first operand per unit |
| iss_vk | output | 6x32 | Issued second operand per unit |
| iss_dst | output | 6x3 | Issued destination index per unit |

## Verification
A station left busy after it issues shows up as the same destination index issued twice, or as an offer refused although a station should be free. A lost operand capture shows up as an instruction that never issues, or issues with a stale value. The bench compares every port in every cycle, so such a fault appears within one or two cycles of the event that caused it. A wrong divider wait shows up as a divide strobe one or more cycles early or late. A wrong age order shows up as a younger destination index on a unit in the very cycle of contention.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;
  parameter int DATA_W  = 32;
  parameter int OP_W    = 4;
  parameter int ROB_N   = 6;
  parameter int TAG_W   = $clog2(ROB_N);
  parameter int NUM_RS  = 4;
  parameter int RS_IW   = $clog2(NUM_RS);
  parameter int N_INT   = 1;
  parameter int N_FADD  = 2;
  parameter int N_FMUL  = 2;
  parameter int N_FDIV  = 1;
  parameter int NUM_FU  = N_INT + N_FADD + N_FMUL + N_FDIV;
  parameter int DIV_LAT = 8;
  parameter int CNT_W   = $clog2(DIV_LAT + 1);
  parameter int DIV_UNIT = NUM_FU - 1;

  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FADD = 2'd1,
    CLS_FMUL = 2'd2,
    CLS_FDIV = 2'd3
  } fu_cls_e;

  typedef struct packed {
    logic              busy;
    fu_cls_e           cls;
    logic [OP_W-1:0]   op;
    logic [DATA_W-1:0] vj;
    logic [DATA_W-1:0] vk;
    logic              pj;
    logic [TAG_W-1:0]  tj;
    logic              pk;
    logic [TAG_W-1:0]  tk;
    logic [TAG_W-1:0]  dst;
  } rs_entry_t;

  // class served by unit index u
  function automatic fu_cls_e unit_class(int u);
    if (u < N_INT) return CLS_INT;
    else if (u < N_INT + N_FADD) return CLS_FADD;
    else if (u < N_INT + N_FADD + N_FMUL) return CLS_FMUL;
    else return CLS_FDIV;
  endfunction

  // distance of a tag from the reorder-buffer head, modulo its depth
  function automatic logic [TAG_W-1:0] rob_age(logic [TAG_W-1:0] tag,
                                               logic [TAG_W-1:0] head);
    if (tag >= head) return tag - head;
    else return TAG_W'(int'(tag) + ROB_N - int'(head));
  endfunction

  // capture a result-bus value into pending operands
  function automatic rs_entry_t snoop(rs_entry_t e, logic v,
                                      logic [TAG_W-1:0] t,
                                      logic [DATA_W-1:0] d);
    rs_entry_t r;
    r = e;
    if (v && e.pj && e.tj == t) begin
      r.vj = d;
      r.pj = 1'b0;
    end
    if (v && e.pk && e.tk == t) begin
      r.vk = d;
      r.pk = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/rs_alloc.sv
module rs_alloc
  import rs_pool_pkg::*;
(
  input  logic              flush,
  input  logic [NUM_RS-1:0] busy,
  input  logic [1:0]        in_valid,
  output logic [1:0]        accept,
  output logic [NUM_RS-1:0] alloc_en,
  output logic [NUM_RS-1:0] alloc_lane
);
  logic [RS_IW-1:0] first_free, second_free;
  logic             have1, have2;

  always_comb begin
    first_free  = '0;
    second_free = '0;
    have1 = 1'b0;
    have2 = 1'b0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (!busy[i]) begin
        if (!have1) begin
          first_free = RS_IW'(i);
          have1 = 1'b1;
        end else if (!have2) begin
          second_free = RS_IW'(i);
          have2 = 1'b1;
        end
      end
    end
    accept[0] = !flush && in_valid[0] && have1;
    accept[1] = !flush && in_valid[1] && (in_valid[0] ? have2 : have1);
    alloc_en   = '0;
    alloc_lane = '0;
    if (accept[0]) alloc_en[first_free] = 1'b1;
    if (accept[1]) begin
      if (accept[0]) begin
        alloc_en[second_free]   = 1'b1;
        alloc_lane[second_free] = 1'b1;
      end else begin
        alloc_en[first_free]   = 1'b1;
        alloc_lane[first_free] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_station.sv
module rs_station
  import rs_pool_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_en,
  input  rs_entry_t         alloc_data,
  input  logic              release_en,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              busy,
  output logic              ready,
  output fu_cls_e           cls,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] vj,
  output logic [DATA_W-1:0] vk,
  output logic [TAG_W-1:0]  dst
);
  rs_entry_t ent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent <= '0;
    end else if (flush) begin
      ent.busy <= 1'b0;
    end else if (alloc_en) begin
      ent <= snoop(alloc_data, cdb_valid, cdb_tag, cdb_data);
    end else begin
      ent <= snoop(ent, cdb_valid, cdb_tag, cdb_data);
      if (release_en) ent.busy <= 1'b0;
    end
  end

  assign busy  = ent.busy;
  assign ready = ent.busy && !ent.pj && !ent.pk;
  assign cls   = ent.cls;
  assign op    = ent.op;
  assign vj    = ent.vj;
  assign vk    = ent.vk;
  assign dst   = ent.dst;
endmodule

// File: rtl/rs_select.sv
module rs_select
  import rs_pool_pkg::*;
(
  input  logic [TAG_W-1:0]  rob_head,
  input  logic [NUM_RS-1:0] st_ready,
  input  fu_cls_e           st_cls [NUM_RS],
  input  logic [TAG_W-1:0]  st_dst [NUM_RS],
  input  logic [NUM_FU-1:0] unit_ok,
  output logic [NUM_FU-1:0] gnt_v,
  output logic [RS_IW-1:0]  gnt_idx [NUM_FU],
  output logic [NUM_RS-1:0] release_rs
);
  localparam int SEL_W = $clog2(NUM_FU + NUM_RS + 1);

  logic [SEL_W-1:0] rank [NUM_RS];
  logic [SEL_W-1:0] slot [NUM_FU];

  always_comb begin
    // rank: number of older ready stations of the same class
    for (int i = 0; i < NUM_RS; i++) begin
      rank[i] = '0;
      for (int j = 0; j < NUM_RS; j++) begin
        if (j != i && st_ready[j] && st_cls[j] == st_cls[i] &&
            rob_age(st_dst[j], rob_head) < rob_age(st_dst[i], rob_head))
          rank[i] = rank[i] + SEL_W'(1);
      end
    end
    // slot: number of accepting lower-index units of the same class
    for (int u = 0; u < NUM_FU; u++) begin
      slot[u] = '0;
      for (int w = 0; w < u; w++) begin
        if (unit_class(w) == unit_class(u) && unit_ok[w])
          slot[u] = slot[u] + SEL_W'(1);
      end
    end
    release_rs = '0;
    for (int u = 0; u < NUM_FU; u++) begin
      gnt_v[u]   = 1'b0;
      gnt_idx[u] = '0;
      if (unit_ok[u]) begin
        for (int i = 0; i < NUM_RS; i++) begin
          if (st_ready[i] && st_cls[i] == unit_class(u) && rank[i] == slot[u]) begin
            gnt_v[u]      = 1'b1;
            gnt_idx[u]    = RS_IW'(i);
            release_rs[i] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pool_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic [TAG_W-1:0]              rob_head,
  input  logic [1:0]                    in_valid,
  input  logic [1:0][1:0]               in_cls,
  input  logic [1:0][OP_W-1:0]          in_op,
  input  logic [1:0][DATA_W-1:0]        in_vj,
  input  logic [1:0][DATA_W-1:0]        in_vk,
  input  logic [1:0]                    in_pj,
  input  logic [1:0][TAG_W-1:0]         in_tj,
  input  logic [1:0]                    in_pk,
  input  logic [1:0][TAG_W-1:0]         in_tk,
  input  logic [1:0][TAG_W-1:0]         in_dst,
  input  logic                          cdb_valid,
  input  logic [TAG_W-1:0]              cdb_tag,
  input  logic [DATA_W-1:0]             cdb_data,
  input  logic [NUM_FU-1:0]             fu_stall,
  output logic [1:0]                    in_accept,
  output logic [NUM_FU-1:0]             iss_valid,
  output logic [NUM_FU-1:0][OP_W-1:0]   iss_op,
  output logic [NUM_FU-1:0][DATA_W-1:0] iss_vj,
  output logic [NUM_FU-1:0][DATA_W-1:0] iss_vk,
  output logic [NUM_FU-1:0][TAG_W-1:0]  iss_dst
);
  // named internal events, also observed by the checker
  logic [NUM_RS-1:0] st_busy, st_ready, alloc_en, alloc_lane, release_rs;
  logic [NUM_FU-1:0] unit_ok, gnt_v;
  logic              div_issue;

  fu_cls_e           st_cls [NUM_RS];
  logic [OP_W-1:0]   st_op  [NUM_RS];
  logic [DATA_W-1:0] st_vj  [NUM_RS];
  logic [DATA_W-1:0] st_vk  [NUM_RS];
  logic [TAG_W-1:0]  st_dst [NUM_RS];
  logic [RS_IW-1:0]  gnt_idx [NUM_FU];
  logic [CNT_W-1:0]  div_cnt;

  rs_alloc u_alloc (
    .flush(flush), .busy(st_busy), .in_valid(in_valid),
    .accept(in_accept), .alloc_en(alloc_en), .alloc_lane(alloc_lane)
  );

  for (genvar i = 0; i < NUM_RS; i++) begin : g_rs
    logic      ln;
    rs_entry_t init;
    assign ln   = alloc_lane[i];
    assign init = '{busy: 1'b1, cls: fu_cls_e'(in_cls[ln]), op: in_op[ln],
                    vj: in_vj[ln], vk: in_vk[ln], pj: in_pj[ln], tj: in_tj[ln],
                    pk: in_pk[ln], tk: in_tk[ln], dst: in_dst[ln]};
    rs_station u_st (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .alloc_en(alloc_en[i]), .alloc_data(init), .release_en(release_rs[i]),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .busy(st_busy[i]), .ready(st_ready[i]), .cls(st_cls[i]), .op(st_op[i]),
      .vj(st_vj[i]), .vk(st_vk[i]), .dst(st_dst[i])
    );
  end

  always_comb begin
    for (int u = 0; u < NUM_FU; u++)
      unit_ok[u] = !flush && !fu_stall[u] && (u != DIV_UNIT || div_cnt == '0);
  end

  rs_select u_sel (
    .rob_head(rob_head), .st_ready(st_ready), .st_cls(st_cls), .st_dst(st_dst),
    .unit_ok(unit_ok), .gnt_v(gnt_v), .gnt_idx(gnt_idx), .release_rs(release_rs)
  );

  assign div_issue = gnt_v[DIV_UNIT];

  // blocking divider: countdown of cycles before the next divide may start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else if (div_issue) div_cnt <= CNT_W'(DIV_LAT - 1);
    else if (div_cnt != '0) div_cnt <= div_cnt - CNT_W'(1);
  end

  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      iss_valid[u] = gnt_v[u];
      iss_op[u]    = st_op[gnt_idx[u]];
      iss_vj[u]    = st_vj[gnt_idx[u]];
      iss_vk[u]    = st_vk[gnt_idx[u]];
      iss_dst[u]   = st_dst[gnt_idx[u]];
    end
  end
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk
  import rs_pool_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic [1:0]        in_accept,
  input logic [NUM_FU-1:0] iss_valid,
  input logic [NUM_RS-1:0] st_busy
);
  logic [CNT_W-1:0] gap;

  // cycles since the last divide start, saturating at the divider latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= CNT_W'(DIV_LAT);
    else if (iss_valid[DIV_UNIT]) gap <= CNT_W'(1);
    else if (gap < CNT_W'(DIV_LAT)) gap <= gap + CNT_W'(1);
  end

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> st_busy == '0);

  assert_flush_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (iss_valid == '0 && in_accept == '0));

  assert_div_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[DIV_UNIT] |-> gap >= CNT_W'(DIV_LAT));

  assert_occupancy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> ($countones(st_busy) == $past($countones(st_busy))
                + $past($countones(in_accept)) - $past($countones(iss_valid))));

  assert_room_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_accept == 2'b11) |-> $countones(~st_busy) >= 2);

  assert_room_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_accept != 2'b00) |-> st_busy != '1);

  assert_issue_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_valid) <= $countones(st_busy));
endmodule

bind rs_pool rs_pool_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_accept(in_accept),
  .iss_valid(iss_valid), .st_busy(st_busy)
);

// File: tb/rs_pool_tb.sv
module rs_pool_tb;
  import rs_pool_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [TAG_W-1:0] rob_head = '0;
  logic [1:0] in_valid = '0, in_pj = '0, in_pk = '0;
  logic [1:0][1:0] in_cls = '0;
  logic [1:0][OP_W-1:0] in_op = '0;
  logic [1:0][DATA_W-1:0] in_vj = '0, in_vk = '0;
  logic [1:0][TAG_W-1:0] in_tj = '0, in_tk = '0, in_dst = '0;
  logic cdb_valid = 1'b0;
  logic [TAG_W-1:0] cdb_tag = '0;
  logic [DATA_W-1:0] cdb_data = '0;
  logic [NUM_FU-1:0] fu_stall = '0;
  logic [1:0] in_accept;
  logic [NUM_FU-1:0] iss_valid;
  logic [NUM_FU-1:0][OP_W-1:0] iss_op;
  logic [NUM_FU-1:0][DATA_W-1:0] iss_vj, iss_vk;
  logic [NUM_FU-1:0][TAG_W-1:0] iss_dst;

  rs_pool u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model of the stations
  bit m_busy [NUM_RS], m_pj [NUM_RS], m_pk [NUM_RS];
  int m_cls [NUM_RS], m_tj [NUM_RS], m_tk [NUM_RS], m_dst [NUM_RS];
  logic [OP_W-1:0] m_op [NUM_RS];
  logic [DATA_W-1:0] m_vj [NUM_RS], m_vk [NUM_RS];
  int m_gap = DIV_LAT;
  int unit_cls_tab [NUM_FU] = '{0, 1, 1, 2, 2, 3};

  function automatic int age(int t);
    return (t - int'(rob_head) + ROB_N) % ROB_N;
  endfunction

  function automatic int free_count();
    int n = 0;
    for (int i = 0; i < NUM_RS; i++) if (!m_busy[i]) n++;
    return n;
  endfunction

  task automatic check(bit ok, string tag, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  task automatic model_alloc(int s, int l);
    m_busy[s] = 1; m_cls[s] = int'(in_cls[l]); m_op[s] = in_op[l];
    m_vj[s] = in_vj[l]; m_vk[s] = in_vk[l];
    m_pj[s] = in_pj[l]; m_tj[s] = int'(in_tj[l]);
    m_pk[s] = in_pk[l]; m_tk[s] = int'(in_tk[l]);
    m_dst[s] = int'(in_dst[l]);
  endtask

  task automatic model_snoop(int s);
    if (cdb_valid && m_pj[s] && m_tj[s] == int'(cdb_tag)) begin m_vj[s] = cdb_data; m_pj[s] = 0; end
    if (cdb_valid && m_pk[s] && m_tk[s] == int'(cdb_tag)) begin m_vk[s] = cdb_data; m_pk[s] = 0; end
  endtask

  // one cycle: compare all outputs, then advance the model at the edge
  task automatic step(string tag);
    bit e_acc [2];
    bit taken [NUM_RS];
    bit e_v [NUM_FU];
    int e_sel [NUM_FU];
    int fl [2];
    int nf, k;
    #1;
    nf = free_count();
    e_acc[0] = !flush && in_valid[0] && nf >= 1;
    e_acc[1] = !flush && in_valid[1] && nf >= (in_valid[0] ? 2 : 1);
    check(in_accept == {e_acc[1], e_acc[0]}, tag,
          $sformatf("accept got %b exp %b", in_accept, {e_acc[1], e_acc[0]}));
    for (int i = 0; i < NUM_RS; i++) taken[i] = 0;
    for (int u = 0; u < NUM_FU; u++) begin
      int best = -1;
      bit ok = !flush && !fu_stall[u] && (u != DIV_UNIT || m_gap >= DIV_LAT);
      e_v[u] = 0; e_sel[u] = 0;
      if (ok) begin
        for (int i = 0; i < NUM_RS; i++)
          if (m_busy[i] && !m_pj[i] && !m_pk[i] && m_cls[i] == unit_cls_tab[u] && !taken[i] &&
              (best < 0 || age(m_dst[i]) < age(m_dst[best]))) best = i;
      end
      if (best >= 0) begin e_v[u] = 1; e_sel[u] = best; taken[best] = 1; end
      if (e_v[u])
        check(iss_valid[u] && iss_op[u] == m_op[best] && iss_vj[u] == m_vj[best] &&
              iss_vk[u] == m_vk[best] && int'(iss_dst[u]) == m_dst[best], tag,
              $sformatf("unit %0d got v=%0d op=%h a=%h b=%h d=%0d exp v=1 op=%h a=%h b=%h d=%0d",
                        u, iss_valid[u], iss_op[u], iss_vj[u], iss_vk[u], iss_dst[u],
                        m_op[best], m_vj[best], m_vk[best], m_dst[best]));
      else
        check(!iss_valid[u], tag, $sformatf("unit %0d got v=%0d exp v=0", u, iss_valid[u]));
    end
    @(posedge clk);
    k = 0; fl[0] = 0; fl[1] = 0;
    for (int i = 0; i < NUM_RS; i++) if (!m_busy[i] && k < 2) begin fl[k] = i; k++; end
    if (flush) begin
      for (int i = 0; i < NUM_RS; i++) m_busy[i] = 0;
    end else begin
      for (int i = 0; i < NUM_RS; i++)
        if (taken[i]) m_busy[i] = 0; else if (m_busy[i]) model_snoop(i);
      if (e_acc[0]) begin model_alloc(fl[0], 0); model_snoop(fl[0]); end
      if (e_acc[1]) begin
        int s = e_acc[0] ? fl[1] : fl[0];
        model_alloc(s, 1); model_snoop(s);
      end
    end
    if (e_v[DIV_UNIT]) m_gap = 1; else if (m_gap < DIV_LAT) m_gap++;
    @(negedge clk);
  endtask

  task automatic clear_in();
    in_valid = '0; in_pj = '0; in_pk = '0; cdb_valid = 0; flush = 0; fu_stall = '0;
  endtask

  task automatic set_lane(int l, int cls, bit pj, int tj, int dst);
    in_valid[l] = 1; in_cls[l] = 2'(cls); in_op[l] = OP_W'($urandom);
    in_vj[l] = $urandom; in_vk[l] = $urandom;
    in_pj[l] = pj; in_tj[l] = TAG_W'(tj); in_pk[l] = 0; in_tk[l] = '0;
    in_dst[l] = TAG_W'(dst);
  endtask

  task automatic empty_pool();
    clear_in(); flush = 1; step("R10"); flush = 0;
  endtask

  task automatic rand_in();
    bit used [ROB_N];
    int d0, d1;
    for (int t = 0; t < ROB_N; t++) used[t] = 0;
    for (int i = 0; i < NUM_RS; i++) if (m_busy[i]) used[m_dst[i]] = 1;
    d0 = 0; while (used[d0]) d0++;
    used[d0] = 1;
    d1 = 0; while (used[d1]) d1++;
    for (int l = 0; l < 2; l++) begin
      set_lane(l, $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, ROB_N-1),
               l == 0 ? d0 : d1);
      in_valid[l] = ($urandom_range(0, 2) != 0);
      in_pk[l] = ($urandom_range(0, 3) == 0);
      in_tk[l] = TAG_W'($urandom_range(0, ROB_N-1));
    end
    cdb_valid = $urandom_range(0, 1);
    cdb_tag = TAG_W'($urandom_range(0, ROB_N-1));
    cdb_data = $urandom;
    for (int u = 0; u < NUM_FU; u++) fu_stall[u] = ($urandom_range(0, 3) == 0);
    flush = ($urandom_range(0, 49) == 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 got hung exp finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle after reset, then a pair is taken
    clear_in(); step("R1");
    set_lane(0, 0, 0, 0, 0); set_lane(1, 0, 0, 0, 1); step("R1");
    // R3: one integer unit, older issues first, next one after
    clear_in(); step("R3"); step("R3"); step("R3");
    // R4: capture from the result bus while being accepted
    empty_pool();
    set_lane(0, 1, 1, 5, 2); cdb_valid = 1; cdb_tag = 3'd5; cdb_data = 32'hCAFE0001;
    step("R4");
    clear_in(); step("R4");
    set_lane(0, 1, 1, 4, 3); step("R4");
    clear_in(); step("R4"); step("R4");
    cdb_valid = 1; cdb_tag = 3'd4; cdb_data = 32'h1234ABCD; step("R4");
    clear_in(); step("R4"); step("R4");
    // R9: back-to-back divides wait for the divider
    empty_pool();
    set_lane(0, 3, 0, 0, 0); set_lane(1, 3, 0, 0, 1); step("R9");
    clear_in(); for (int n = 0; n < 11; n++) step("R9");
    // R6 / R7: ages wrap around the head; multiplier units in index order
    empty_pool();
    rob_head = 3'd4;
    fu_stall = 6'b011000;
    set_lane(0, 2, 0, 0, 0); set_lane(1, 2, 0, 0, 5); step("R6");
    set_lane(0, 2, 0, 0, 1); set_lane(1, 2, 0, 0, 4); step("R6");
    in_valid = '0; step("R6");
    fu_stall = 6'b001000; step("R7");
    fu_stall = '0; step("R7"); step("R6");
    // R8: stalled unit keeps its station
    empty_pool(); rob_head = '0;
    set_lane(0, 0, 0, 0, 2); fu_stall = 6'b000001; step("R8");
    in_valid = '0; step("R8"); step("R8");
    fu_stall = '0; step("R8"); step("R8");
    // R2 / R11: full pool refuses, freed station is taken next cycle
    empty_pool();
    fu_stall = '1;
    set_lane(0, 1, 0, 0, 0); set_lane(1, 1, 0, 0, 1); step("R2");
    set_lane(0, 1, 0, 0, 2); set_lane(1, 1, 0, 0, 3); step("R2");
    set_lane(0, 1, 0, 0, 4); set_lane(1, 1, 0, 0, 5); step("R2");
    in_valid = 2'b10; step("R2");
    fu_stall = 6'b111101; in_valid = '0; step("R11");
    set_lane(0, 1, 0, 0, 0); set_lane(1, 1, 0, 0, 4); step("R11");
    fu_stall = '1; in_valid = '0; step("R11");
    // R10: flush with a busy pool
    set_lane(0, 0, 0, 0, 1); step("R10");
    empty_pool(); step("R10");
    // R5: random traffic over all classes and units
    for (int c = 0; c < 3000; c++) begin
      if (c % 50 == 0) rob_head = TAG_W'($urandom_range(0, ROB_N-1));
      rand_in();
      step("R5");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule